// File: doc/BRIEF.md
# Configurable Interrupt Aggregator

This block gathers the interrupt sources of a serial peripheral host (a device interrupt from the attached card, a controller interrupt from the FIFO logic and a write-FIFO-empty interrupt) into one interrupt line toward the host bus. For each source, software picks whether it is level or edge sensitive and whether it is active high or active low. Each source then sets its own bit in a status register. A mask register decides which status bits may drive the output.

Software reaches the block through a simple register port. A write is one cycle with an address and data. A read is combinational on the selected address. Edge-latched status bits are acknowledged by writing 1 to them. A level-sensitive bit tracks its conditioned input and comes back while that input stays active. Writing zero to the mask, edge and polarity registers puts the block back in its unconfigured state. The source inputs must already be synchronous to `clk_i`.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, every register reads 0 and `irq_o` is 0.
- R2: Address 1 is the mask, address 2 is the edge select and address 3 is the polarity select. Each keeps the low NUM_SRC bits of the written data, and its upper bits read as 0.
- R3: When a source's edge-select bit is 0, its status bit equals the conditioned input as it was one cycle earlier. A write-1 acknowledge does not clear the bit while the input stays active.
- R4: A polarity bit of 1 makes that source active low, so the conditioned input is the inverse of the raw input. A polarity bit of 0 leaves the source active high.
- R5: When a source's edge-select bit is 1, an inactive-to-active change of its conditioned input sets its status bit one cycle later. The bit stays set after the input goes inactive again.
- R6: Writing status (address 0) clears each edge-latched bit whose data bit is 1. Data bits of 0 leave the status unchanged.
- R7: If a new active edge arrives in the same cycle as the acknowledge of that bit, the bit stays set.
- R8: `irq_o` is 1 exactly when some status bit and its mask bit are both 1.
- R9: Source index 0 (device) maps to status bit 0, index 1 (controller) to bit 1, and index 2 (write FIFO empty) to bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_SRC | Raw interrupt sources, synchronous to clk_i |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address: 0 status, 1 mask, 2 edge, 3 polarity |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for addr_i |
| irq_o | output | 1 | Combined interrupt output |

## Verification
The hardest case to reach from the ports is a new edge landing in the very cycle that software acknowledges the same status bit. The bench lowers the source first. It then raises the source and issues the status write in the same cycle, so both reach the same clock edge, and checks that the bit stays set. A second hard case is an acknowledge that must have no effect. The bench holds a level source active, writes 1 to its status bit, and reads the status back before the input is released.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  typedef enum logic [1:0] {
    REG_STAT = 2'd0,
    REG_MASK = 2'd1,
    REG_EDGE = 2'd2,
    REG_POL  = 2'd3
  } irq_reg_e;
endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_i,
  input  logic pol_i,
  input  logic edge_mode_i,
  input  logic ack_i,
  output logic status_o
);
  logic cond, cond_prev_q, status_q, rise;

  assign cond = src_i ^ pol_i;  // pol=1: active low
  assign rise = cond & ~cond_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cond_prev_q <= 1'b0;
      status_q    <= 1'b0;
    end else begin
      cond_prev_q <= cond;
      if (edge_mode_i) status_q <= (status_q & ~ack_i) | rise;
      else             status_q <= cond;
    end
  end

  assign status_o = status_q;

  p_level_follow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !edge_mode_i |=> (status_q == $past(cond)));
  p_edge_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_mode_i && rise) |=> status_q);
  p_edge_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_mode_i && status_q && !ack_i) |=> status_q);
  p_ack_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_mode_i && ack_i && !rise) |=> !status_q);
endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
  import irq_agg_pkg::*;
#(
  parameter int NUM_SRC = 3,
  parameter int DATA_W  = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [1:0]         addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [NUM_SRC-1:0] status_i,
  output logic [NUM_SRC-1:0] mask_o,
  output logic [NUM_SRC-1:0] edge_o,
  output logic [NUM_SRC-1:0] pol_o,
  output logic [NUM_SRC-1:0] ack_o,
  output logic [DATA_W-1:0]  rdata_o
);
  localparam int PAD_W = DATA_W - NUM_SRC;

  logic [NUM_SRC-1:0] mask_q, edge_q, pol_q, sel;
  irq_reg_e reg_sel;

  assign reg_sel = irq_reg_e'(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      edge_q <= '0;
      pol_q  <= '0;
    end else if (wr_en_i) begin
      case (reg_sel)
        REG_MASK: mask_q <= wdata_i[NUM_SRC-1:0];
        REG_EDGE: edge_q <= wdata_i[NUM_SRC-1:0];
        REG_POL:  pol_q  <= wdata_i[NUM_SRC-1:0];
        default:  ;
      endcase
    end
  end

  assign ack_o = (wr_en_i && reg_sel == REG_STAT) ? wdata_i[NUM_SRC-1:0] : '0;

  always_comb begin
    case (reg_sel)
      REG_STAT: sel = status_i;
      REG_MASK: sel = mask_q;
      REG_EDGE: sel = edge_q;
      default:  sel = pol_q;
    endcase
  end

  assign rdata_o = {{PAD_W{1'b0}}, sel};
  assign mask_o  = mask_q;
  assign edge_o  = edge_q;
  assign pol_o   = pol_q;

  p_mask_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 2'd1) |=> (mask_q == $past(wdata_i[NUM_SRC-1:0])));
  p_cfg_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(mask_q) && $stable(edge_q) && $stable(pol_q)));
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int NUM_SRC = 3,
  parameter int DATA_W  = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               wr_en_i,
  input  logic [1:0]         addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] mask, edge_sel, pol, ack, status;

  irq_regfile #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .status_i(status), .mask_o(mask), .edge_o(edge_sel), .pol_o(pol),
    .ack_o(ack), .rdata_o
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    irq_src_cell u_cell (
      .clk_i, .rst_ni,
      .src_i(src_i[i]), .pol_i(pol[i]), .edge_mode_i(edge_sel[i]),
      .ack_i(ack[i]), .status_o(status[i])
    );
  end

  assign irq_o = |(status & mask);

  p_quiet_unmasked_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask == '0) |-> !irq_o);
  p_quiet_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status == '0) |-> !irq_o);
endmodule

// File: tb/irq_aggregator_bench.sv
module irq_aggregator_bench;
  logic        clk = 0, rst_n = 0;
  logic [2:0]  src = '0;
  logic        wr_en = 0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        irq;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  irq_aggregator u_irq_aggregator (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    wr_en = 1; addr = a; wdata = d;
    tick();
    wr_en = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d); check("R1 reg", d, 0);
    end
    check("R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_cfg();
    logic [31:0] d;
    wr(2'd1, 32'hFFFF_FFFF); rd(2'd1, d); check("R2 mask", d, 32'h7);
    wr(2'd2, 32'h8000_0000); rd(2'd2, d); check("R2 edge", d, 32'h0);
    wr(2'd3, 32'h4000_0004); rd(2'd3, d); check("R2 pol", d, 32'h4);
    wr(2'd1, 0); wr(2'd2, 0); wr(2'd3, 0);
    rd(2'd3, d); check("R2 pol clr", d, 0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    wr(2'd1, 32'h1);
    src = 3'b001; tick();
    rd(2'd0, d); check("R3/R9 device bit0", d, 32'h1);
    check("R8 irq on", {31'b0, irq}, 1);
    wr(2'd0, 32'h1); rd(2'd0, d); check("R3 ack ignored", d, 32'h1);
    src = 3'b000; tick();
    rd(2'd0, d); check("R3 follow low", d, 0);
    check("R8 irq off", {31'b0, irq}, 0);
  endtask

  task automatic t_pol();
    logic [31:0] d;
    wr(2'd1, 32'h0);
    wr(2'd3, 32'h4); tick();
    rd(2'd0, d); check("R4/R9 wfifo low active", d, 32'h4);
    check("R8 masked", {31'b0, irq}, 0);
    wr(2'd1, 32'h4); check("R8 unmasked", {31'b0, irq}, 1);
    src = 3'b100; tick();
    rd(2'd0, d); check("R4 high inactive", d, 0);
    wr(2'd3, 0); src = 0; tick(); wr(2'd1, 0);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    wr(2'd2, 32'h2); wr(2'd1, 32'h2);
    src = 3'b010; tick(); src = 0; tick();
    rd(2'd0, d); check("R5/R9 ctrl latched", d, 32'h2);
    check("R8 edge irq", {31'b0, irq}, 1);
    wr(2'd0, 32'h5); rd(2'd0, d); check("R6 zero bit keeps", d, 32'h2);
    wr(2'd0, 32'h2); rd(2'd0, d); check("R6 ack clears", d, 0);
    check("R8 irq cleared", {31'b0, irq}, 0);
  endtask

  task automatic t_race();
    logic [31:0] d;
    src = 3'b010; tick(); src = 0; tick();
    wr_en = 1; addr = 2'd0; wdata = 32'h2; src = 3'b010;
    tick(); wr_en = 0;
    rd(2'd0, d); check("R7 edge beats ack", d, 32'h2);
    src = 0; wr(2'd0, 32'h2); rd(2'd0, d); check("R7 later ack", d, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1; @(negedge clk);
        t_reset(); t_cfg(); t_level(); t_pol(); t_edge(); t_race();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog got=timeout exp=done");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule